// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shifter

This block is a byte-wide synchronous serial port that acts as clock master. It drives a serial clock output, shifts data out on a serial data output and captures data from a serial data input. A host controls it through plain pins: an enable level, a mode level, one-cycle write and read strobes on a single shift register, and a clear strobe for the completion flag. The serial clock is derived from the system clock. Each half-period lasts `HALF_CLKS` system clocks.

In transmit/receive mode, writing the register starts a transfer. In receive-only mode, reading the register starts a transfer, so software can fetch one byte and launch the next with the same access. After the last bit the port stops by itself and raises a completion flag. The write and read strobes are single-cycle requests with no back-pressure. No ready signal exists. A strobe that lands while a byte is moving is dropped, and software must wait for the flag before it accesses the register again. The serial pins carry no handshake.

Top module: `tw_serial_port`

## Requirements
- R1: After reset, `sck` is 1, `so` is 0, `done` is 0 and `rd_data` is 0.
- R2: With `en`=1 and `mode`=0, a `wr_stb` while idle loads `wr_data` and starts a transfer. In the cycle after the strobe edge, `sck` is 0 and `so` carries bit 7 of `wr_data`.
- R3: A transfer has exactly 8 serial clock periods. Each period is `HALF_CLKS` system clocks low followed by `HALF_CLKS` high.
- R4: `so` changes only on a falling `sck` edge. Bits go out most significant first.
- R5: `si` is captured on each rising `sck` edge, first bit into bit 7. After the transfer, `rd_data` holds the received byte.
- R6: With `en`=1 and `mode`=1, a `rd_stb` while idle starts a transfer. A `wr_stb` in this mode only loads the register and does not start one.
- R7: A `wr_stb` while `en`=0 loads the register but starts nothing, even after `en` is later set to 1.
- R8: After the eighth rising `sck` edge, the port stops with `sck` held at 1 and sets `done`.
- R9: `done` stays set until a `flag_clr` strobe clears it, or until the next transfer starts.
- R10: `wr_stb` and `rd_stb` during a transfer are ignored. They neither restart the transfer nor alter the data being shifted.
- R11: While idle, `so` holds the last bit it drove.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| mode | input | 1 | 0 = transmit/receive, 1 = receive-only |
| wr_stb | input | 1 | One-cycle register write strobe |
| wr_data | input | WIDTH | Byte to load |
| rd_stb | input | 1 | One-cycle register read strobe |
| rd_data | output | WIDTH | Current shift register contents |
| flag_clr | input | 1 | One-cycle completion flag clear |
| sck | output | 1 | Serial clock, idle high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| done | output | 1 | Completion flag |

## Verification
The bench builds the port with `HALF_CLKS` = 3 and `WIDTH` = 8. A half-period of several clocks lets the reference model separate the divider count from the edge events. This exposes off-by-one errors in the divider and a misplaced sample or drive point within a half-period. The bench runs transfers started by write and by read, accesses made while disabled, and strobes made mid-transfer. A device model drives `si` so that each received byte differs from the byte sent.

// File: rtl/tw_serial_pkg.sv
package tw_serial_pkg;
  typedef enum logic {
    MODE_TXRX   = 1'b0,
    MODE_RXONLY = 1'b1
  } port_mode_e;
endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LIM = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LIM) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LIM);
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             sample,
  input  logic             drive,
  input  logic             si,
  output logic [WIDTH-1:0] sr,
  output logic             so
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      so <= 1'b0;
    end else begin
      if (load)        sr <= load_data;
      else if (sample) sr <= {sr[WIDTH-2:0], si};
      if (drive)       so <= load ? load_data[WIDTH-1] : sr[WIDTH-1];
    end
  end
endmodule

// File: rtl/tw_serial_port.sv
module tw_serial_port
  import tw_serial_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter int HALF_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode,
  input  logic             wr_stb,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_stb,
  output logic [WIDTH-1:0] rd_data,
  input  logic             flag_clr,
  output logic             sck,
  output logic             so,
  input  logic             si,
  output logic             done
);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WIDTH - 1);

  port_mode_e mode_e;
  logic busy, tick, start, load, rise, fall, last;
  logic [BW-1:0] bits;

  assign mode_e = port_mode_e'(mode);
  assign load   = !busy && wr_stb;
  assign start  = !busy && en &&
                  ((mode_e == MODE_TXRX) ? wr_stb : rd_stb);
  assign rise   = busy && tick && !sck;
  assign fall   = busy && tick && sck;
  assign last   = rise && (bits == LAST_BIT);

  tw_tick_gen #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  tw_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
    .sample(rise), .drive(start || fall), .si(si),
    .sr(rd_data), .so(so)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sck  <= 1'b1;
      bits <= '0;
      done <= 1'b0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        sck  <= 1'b0;
        bits <= '0;
      end else if (rise) begin
        sck  <= 1'b1;
        bits <= bits + 1'b1;
        if (last) busy <= 1'b0;
      end else if (fall) begin
        sck  <= 1'b0;
      end
      if (last)                   done <= 1'b1;
      else if (start || flag_clr) done <= 1'b0;
    end
  end

  // R2
  start_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sck);
  // R8
  end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sck && done));
  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);
  // R4
  so_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> $fell(sck));
  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

// File: tb/tw_serial_port_bench.sv
`timescale 1ns/1ps
module tw_serial_port_bench;
  localparam int WIDTH = 8;
  localparam int HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, mode = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0, flag_clr = 1'b0;
  logic si = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic sck, so, done;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state
  int m_busy = 0, m_div = 0, m_nb = 0, m_sck = 1, m_so = 0, m_sr = 0, m_flag = 0;
  int rx_byte = 0, falls = 0, prev_sck = 1;

  always #10 clk = ~clk;

  tw_serial_port #(.WIDTH(WIDTH), .HALF_CLKS(HALF)) u_tw_serial_port (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .flag_clr(flag_clr), .sck(sck), .so(so), .si(si), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // behavioural reference, updated on each rising clock edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy == 0) begin
        if (wr_stb) m_sr = int'(wr_data);
        if (en && (mode ? rd_stb : wr_stb)) begin
          m_busy = 1; m_sck = 0; m_div = 0; m_nb = 0;
          m_so = (m_sr >> 7) & 1; m_flag = 0;
        end else if (flag_clr) m_flag = 0;
      end else begin
        if (flag_clr) m_flag = 0;
        m_div++;
        if (m_div == HALF) begin
          m_div = 0;
          if (m_sck == 0) begin
            m_sck = 1;
            m_sr = ((m_sr << 1) | int'(si)) & 255;
            m_nb++;
            if (m_nb == 8) begin m_busy = 0; m_flag = 1; end
          end else begin
            m_sck = 0;
            m_so = (m_sr >> 7) & 1;
          end
        end
      end
    end
  end

  // compare every cycle away from the active edge; device model drives si
  always @(negedge clk) begin
    if (rst_n) begin
      check(sck == m_sck[0],            "R3 sck",   sck, m_sck);
      check(so == m_so[0],              "R4 so",    so, m_so);
      check(rd_data == m_sr[WIDTH-1:0], "R5 data",  rd_data, m_sr);
      check(done == m_flag[0],          "R8 done",  done, m_flag);
      if (prev_sck == 1 && sck == 1'b0) falls++;
      prev_sck = sck;
    end
    si = (m_busy != 0) ? rx_byte[7 - m_nb] : 1'b0;
  end

  task automatic pulse_wr(input logic [7:0] d);
    wr_data = d; wr_stb = 1'b1; @(posedge clk); @(negedge clk); wr_stb = 1'b0;
  endtask
  task automatic pulse_rd();
    rd_stb = 1'b1; @(posedge clk); @(negedge clk); rd_stb = 1'b0;
  endtask
  task automatic pulse_clr();
    flag_clr = 1'b1; @(posedge clk); @(negedge clk); flag_clr = 1'b0;
  endtask
  task automatic wait_done();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(2);
    // R1 reset state
    check(sck == 1'b1 && so == 1'b0 && done == 1'b0 && rd_data == 8'h00, "R1",
          {sck, so, done, rd_data}, 11'h400);
    rst_n = 1'b1;
    idle(2);

    // R2 / R3 / R5 / R8 / R11 write-started transfer
    en = 1'b1; mode = 1'b0; rx_byte = 8'h3C; falls = 0;
    pulse_wr(8'hA5);
    check(sck == 1'b0 && so == 1'b1, "R2 start", {sck, so}, 2'b01);
    wait_done(); idle(1);
    check(done == 1'b1 && sck == 1'b1, "R8 stop", {done, sck}, 2'b11);
    check(rd_data == 8'h3C, "R5 rx", rd_data, 8'h3C);
    check(falls == 8, "R3 periods", falls, 8);
    idle(5);
    check(so == 1'b1, "R11 hold", so, 1);

    // R9 clear strobe
    check(done == 1'b1, "R9 held", done, 1);
    pulse_clr();
    check(done == 1'b0, "R9 clear", done, 0);

    // R10 strobes mid-transfer ignored
    rx_byte = 8'hC3; falls = 0;
    pulse_wr(8'h5A);
    idle(7);
    pulse_wr(8'hFF);
    idle(3);
    pulse_rd();
    wait_done(); idle(1);
    check(rd_data == 8'hC3, "R10 data", rd_data, 8'hC3);
    check(falls == 8, "R10 no restart", falls, 8);
    idle(3);
    check(so == 1'b0, "R11 hold", so, 0);

    // R9 next start clears flag
    rx_byte = 8'h0F;
    pulse_wr(8'h96);
    check(done == 1'b0, "R9 start clears", done, 0);
    wait_done(); idle(2);

    // R6 receive-only: write loads only, read starts
    mode = 1'b1; falls = 0;
    pulse_wr(8'h81);
    idle(10);
    check(sck == 1'b1 && rd_data == 8'h81, "R6 write no start", {sck, rd_data}, 9'h181);
    rx_byte = 8'h7E;
    pulse_rd();
    check(sck == 1'b0 && so == 1'b1, "R6 read start", {sck, so}, 2'b01);
    wait_done(); idle(1);
    check(rd_data == 8'h7E && falls == 8, "R6 rx", rd_data, 8'h7E);

    // R7 write while disabled
    pulse_clr();
    en = 1'b0; mode = 1'b0;
    pulse_wr(8'h11);
    idle(10);
    check(sck == 1'b1 && rd_data == 8'h11, "R7 disabled", {sck, rd_data}, 9'h111);
    en = 1'b1;
    idle(20);
    check(sck == 1'b1 && done == 1'b0, "R7 enable later", {sck, done}, 2'b10);

    finish_run();
  end
endmodule